// File: doc/BRIEF.md
# LIN Wakeup and Bus-Idle Timeout Monitor

This block watches a LIN receive line and the wakeup handshake. It raises three single-cycle pulses for a status register. The first marks a bus that has shown no activity for a long time. The second marks a wakeup signal that no sync break answered. The third marks a whole round of unanswered wakeups after a long waiting period. Time is measured in cycles of a prescaled tick input, so the lengths are set in ticks. With a 1 ms tick, the defaults give 4 s, 150 ms and 1.5 s. The bench sets much shorter values.

Bus activity is a falling edge on the receive line, which goes from recessive (1) to dominant (0). The line first passes through a synchronizer. The idle timer is a two-state machine, `IDL_RUN` and `IDL_SPENT`. It counts ticks in `IDL_RUN`. When its limit is reached it fires and takes the expiry transition to `IDL_SPENT`. It waits there for the rearm transition, which is bus activity. Activity seen in `IDL_RUN` takes the restart transition and clears the count.

The wakeup tracker has four states: `WK_IDLE`, `WK_WAIT1`, `WK_GAP` and `WK_WAIT3`. An accepted wakeup strobe in `WK_IDLE` or `WK_GAP` raises the attempt count. If this was not the last attempt of a round, the tracker takes the launch transition to `WK_WAIT1`. If it was the last attempt, it takes the escalate transition to `WK_WAIT3`. When the short window in `WK_WAIT1` expires, the tracker fires and takes the lapse transition to `WK_GAP`. When the long window in `WK_WAIT3` expires, it fires and takes the round-end transition back to `WK_IDLE`. A sync break, soft reset or leaving LIN mode takes the abort transition to `WK_IDLE` and clears the attempt count.

Top module: `lin_wake_monitor`

## Requirements
- R1: A 1-to-0 transition of `rx_line` counts as bus activity. Once it has crossed the synchronizer, it clears the idle tick count. A line that falls more often than every `IDLE_TICKS` ticks never produces `bus_idle_to`.
- R2: In LIN mode, `IDLE_TICKS` ticks with no activity produce a one-cycle `bus_idle_to` pulse. The pulse appears in the cycle after the clock edge that samples the last tick.
- R3: After `bus_idle_to` fires, no further idle pulse occurs until new bus activity is seen. After that activity the idle count runs again.
- R4: In `WK_IDLE` or `WK_GAP`, a `wake_sent` strobe that is not the last of a round opens a window of `WAKE1_TICKS` ticks. If no sync break arrives, the window ends with a one-cycle `wake_once_to` pulse. No wake pulse can occur without an accepted `wake_sent` before it.
- R5: Take the third wakeup of a round (`WAKE_ROUNDS` = 3). If the two before it ended unanswered, this wakeup opens a window of `WAKE3_TICKS` ticks and produces no `wake_once_to`. That window ends with a one-cycle `wake_round_to` pulse, and the attempt count returns to zero.
- R6: `sync_brk` clears the attempt count and stops both wakeup windows, with priority over a `wake_sent` in the same cycle. No wake pulse follows until a new wakeup strobe.
- R7: A `wake_sent` while a window is open (`WK_WAIT1` or `WK_WAIT3`) is ignored. It neither restarts the window nor counts as an attempt.
- R8: While `lin_mode` is 0, every counter and state is held cleared and no pulse is produced.
- R9: `soft_rst` clears every counter and state, so a window that is running is dropped with no pulse.
- R10: After `rst_n` is deasserted, all three outputs are 0.
- R11: Every pulse lasts one cycle, and `wake_once_to` and `wake_round_to` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of all timers and counts |
| lin_mode | input | 1 | 1 enables the monitor, 0 holds it cleared |
| rx_line | input | 1 | Asynchronous LIN receive line, 1 recessive |
| time_tick | input | 1 | Prescaled time base, one-cycle strobe |
| wake_sent | input | 1 | Strobe: a wakeup signal has been sent |
| sync_brk | input | 1 | Strobe: a sync break has been detected |
| bus_idle_to | output | 1 | Pulse: bus idle timeout |
| wake_once_to | output | 1 | Pulse: single wakeup unanswered |
| wake_round_to | output | 1 | Pulse: round of wakeups unanswered, long wait over |

## Verification
The assertions assume that every input apart from `rx_line` is synchronous to `clk`. They also assume that a reset pulse opens the run. They do not assume that `wake_sent` and `sync_brk` are exclusive or spaced apart. The stimulus therefore draws them independently, so they coincide at times, and toggles `lin_mode` and `soft_rst` in the middle of windows. The random phase only changes `rx_line` at clock-aligned times, well apart. This keeps the falling-edge latency through the synchronizer fixed, so the reference model can track it.

// File: rtl/lin_wm_pkg.sv
package lin_wm_pkg;

    typedef enum logic {
        IDL_RUN,
        IDL_SPENT
    } idle_st_e;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_WAIT1,
        WK_GAP,
        WK_WAIT3
    } wake_st_e;

endpackage

// File: rtl/lin_rx_activity.sv
module lin_rx_activity #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    output logic activity
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Resynchronize the asynchronous line; reset to recessive.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rx_line;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Recessive to dominant transition.
    assign activity = prev_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/lin_idle_timer.sv
module lin_idle_timer
    import lin_wm_pkg::*;
#(
    parameter int IDLE_TICKS = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic activity,
    input  logic tick,
    output logic idle_pulse
);

    localparam int CNT_W = $clog2(IDLE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_TICKS - 1);

    idle_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             fire;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= IDL_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state: restart, expiry and rearm transitions.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (clr) begin
            st_d  = IDL_RUN;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                IDL_RUN: begin
                    if (activity) begin
                        cnt_d = '0;
                    end else if (tick) begin
                        if (cnt_q == CNT_LAST) begin
                            fire  = 1'b1;
                            st_d  = IDL_SPENT;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                IDL_SPENT: begin
                    if (activity) begin
                        st_d  = IDL_RUN;
                        cnt_d = '0;
                    end
                end
            endcase
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_pulse <= 1'b0;
        else        idle_pulse <= fire;
    end

endmodule

// File: rtl/lin_wake_tracker.sv
module lin_wake_tracker
    import lin_wm_pkg::*;
#(
    parameter int WAKE1_TICKS = 150,
    parameter int WAKE3_TICKS = 1500,
    parameter int WAKE_ROUNDS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wake_sent,
    input  logic sync_brk,
    input  logic tick,
    output logic once_pulse,
    output logic round_pulse
);

    localparam int LONGEST = (WAKE3_TICKS > WAKE1_TICKS) ? WAKE3_TICKS : WAKE1_TICKS;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam int ATT_W   = $clog2(WAKE_ROUNDS + 1);
    localparam logic [CNT_W-1:0] ONCE_LAST  = CNT_W'(WAKE1_TICKS - 1);
    localparam logic [CNT_W-1:0] ROUND_LAST = CNT_W'(WAKE3_TICKS - 1);
    localparam logic [ATT_W-1:0] ATT_FINAL  = ATT_W'(WAKE_ROUNDS - 1);

    wake_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [ATT_W-1:0] att_q, att_d;
    logic             once_fire, round_fire;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WK_IDLE;
            cnt_q <= '0;
            att_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            att_q <= att_d;
        end
    end

    // Next state: abort, launch, escalate, lapse and round-end transitions.
    always_comb begin
        st_d       = st_q;
        cnt_d      = cnt_q;
        att_d      = att_q;
        once_fire  = 1'b0;
        round_fire = 1'b0;
        if (clr || sync_brk) begin
            st_d  = WK_IDLE;
            cnt_d = '0;
            att_d = '0;
        end else begin
            unique case (st_q)
                WK_IDLE, WK_GAP: begin
                    if (wake_sent) begin
                        cnt_d = '0;
                        att_d = att_q + 1'b1;
                        st_d  = (att_q == ATT_FINAL) ? WK_WAIT3 : WK_WAIT1;
                    end
                end
                WK_WAIT1: begin
                    if (tick) begin
                        if (cnt_q == ONCE_LAST) begin
                            once_fire = 1'b1;
                            st_d      = WK_GAP;
                            cnt_d     = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                WK_WAIT3: begin
                    if (tick) begin
                        if (cnt_q == ROUND_LAST) begin
                            round_fire = 1'b1;
                            st_d       = WK_IDLE;
                            cnt_d      = '0;
                            att_d      = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            once_pulse  <= 1'b0;
            round_pulse <= 1'b0;
        end else begin
            once_pulse  <= once_fire;
            round_pulse <= round_fire;
        end
    end

endmodule

// File: rtl/lin_wake_monitor.sv
module lin_wake_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_TICKS  = 4000,
    parameter int WAKE1_TICKS = 150,
    parameter int WAKE3_TICKS = 1500,
    parameter int WAKE_ROUNDS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic lin_mode,
    input  logic rx_line,
    input  logic time_tick,
    input  logic wake_sent,
    input  logic sync_brk,
    output logic bus_idle_to,
    output logic wake_once_to,
    output logic wake_round_to
);

    logic clr;
    logic activity;

    assign clr = soft_rst | ~lin_mode;

    lin_rx_activity #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_line  (rx_line),
        .activity (activity)
    );

    lin_idle_timer #(
        .IDLE_TICKS (IDLE_TICKS)
    ) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .activity   (activity),
        .tick       (time_tick),
        .idle_pulse (bus_idle_to)
    );

    lin_wake_tracker #(
        .WAKE1_TICKS (WAKE1_TICKS),
        .WAKE3_TICKS (WAKE3_TICKS),
        .WAKE_ROUNDS (WAKE_ROUNDS)
    ) u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .wake_sent   (wake_sent),
        .sync_brk    (sync_brk),
        .tick        (time_tick),
        .once_pulse  (wake_once_to),
        .round_pulse (wake_round_to)
    );

endmodule

// File: rtl/lin_wake_monitor_checker.sv
module lin_wake_monitor_checker (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic lin_mode,
    input logic wake_sent,
    input logic sync_brk,
    input logic bus_idle_to,
    input logic wake_once_to,
    input logic wake_round_to
);

    // Tracks whether a wakeup strobe has been taken since the last wake pulse or abort.
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                armed_q <= 1'b0;
        else if (soft_rst || !lin_mode || sync_brk) armed_q <= 1'b0;
        else if (wake_sent)                         armed_q <= 1'b1;
        else if (wake_once_to || wake_round_to)     armed_q <= 1'b0;
    end

    p_wake_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wake_once_to, wake_round_to}));

    p_once_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_once_to |=> !wake_once_to);

    p_round_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_round_to |=> !wake_round_to);

    p_idle_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle_to |=> !bus_idle_to);

    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lin_mode |=> !(bus_idle_to || wake_once_to || wake_round_to));

    p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !(bus_idle_to || wake_once_to || wake_round_to));

    p_brk_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_brk |=> !(wake_once_to || wake_round_to));

    p_wake_needs_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_once_to || wake_round_to) |-> armed_q);

endmodule

bind lin_wake_monitor lin_wake_monitor_checker u_chk (.*);

// File: tb/lin_wake_monitor_bench.sv
`timescale 1ns/1ps
module lin_wake_monitor_bench;

    localparam int SYNC = 2;
    localparam int IDLE = 24;
    localparam int W1   = 6;
    localparam int W3   = 14;
    localparam int RND  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, lin_mode = 1'b1, rx_line = 1'b1;
    logic time_tick = 1'b0, wake_sent = 1'b0, sync_brk = 1'b0;
    logic bus_idle_to, wake_once_to, wake_round_to;

    always #2.5 clk = ~clk;

    lin_wake_monitor #(
        .SYNC_STAGES (SYNC), .IDLE_TICKS (IDLE), .WAKE1_TICKS (W1),
        .WAKE3_TICKS (W3), .WAKE_ROUNDS (RND)
    ) u_lin_wake_monitor (
        .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst), .lin_mode (lin_mode),
        .rx_line (rx_line), .time_tick (time_tick), .wake_sent (wake_sent),
        .sync_brk (sync_brk), .bus_idle_to (bus_idle_to),
        .wake_once_to (wake_once_to), .wake_round_to (wake_round_to)
    );

    int n_cmp = 0, n_bad = 0;
    int c_idle = 0, c_once = 0, c_round = 0;
    int tick_rand = 0;
    string phase = "R10";
    bit done = 0;

    // Reference model built from the requirements.
    int  m_line[SYNC];
    int  m_last;
    int  m_icnt, m_ispent, m_wst, m_watt, m_wcnt;
    bit  m_idle, m_once, m_round;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC; i++) m_line[i] = 1;
            m_last = 1; m_icnt = 0; m_ispent = 0; m_wst = 0; m_watt = 0; m_wcnt = 0;
            m_idle = 0; m_once = 0; m_round = 0;
        end else begin
            bit act;
            bit off;
            act = (m_last == 1) && (m_line[SYNC-1] == 0);
            m_last = m_line[SYNC-1];
            for (int i = SYNC-1; i > 0; i--) m_line[i] = m_line[i-1];
            m_line[0] = rx_line;
            off = soft_rst || !lin_mode;
            m_idle = 0; m_once = 0; m_round = 0;
            if (off) begin
                m_icnt = 0; m_ispent = 0;
            end else if (act) begin
                m_icnt = 0; m_ispent = 0;
            end else if (!m_ispent && time_tick) begin
                m_icnt++;
                if (m_icnt == IDLE) begin m_idle = 1; m_ispent = 1; m_icnt = 0; end
            end
            if (off || sync_brk) begin
                m_wst = 0; m_watt = 0; m_wcnt = 0;
            end else if (m_wst == 0 || m_wst == 2) begin
                if (wake_sent) begin
                    m_watt++; m_wcnt = 0;
                    m_wst = (m_watt == RND) ? 3 : 1;
                end
            end else if (time_tick) begin
                m_wcnt++;
                if (m_wst == 1 && m_wcnt == W1) begin
                    m_once = 1; m_wst = 2; m_wcnt = 0;
                end else if (m_wst == 3 && m_wcnt == W3) begin
                    m_round = 1; m_wst = 0; m_wcnt = 0; m_watt = 0;
                end
            end
        end
    end

    function automatic int gap_after(int ticks);
        return ticks + SYNC + 4;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        chk(phase, "bus_idle_to", bus_idle_to, m_idle);
        chk(phase, "wake_once_to", wake_once_to, m_once);
        chk(phase, "wake_round_to", wake_round_to, m_round);
        c_idle  += bus_idle_to;
        c_once  += wake_once_to;
        c_round += wake_round_to;
        time_tick = tick_rand ? ($urandom % 2 == 0) : 1'b1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_counts();
        c_idle = 0; c_once = 0; c_round = 0;
    endtask

    task automatic pulse_wake();
        wake_sent = 1'b1; step(); wake_sent = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R10 actual=running expected=finished");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        time_tick = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk("R10", "idle at reset", bus_idle_to, 0);
        chk("R10", "once at reset", wake_once_to, 0);
        chk("R10", "round at reset", wake_round_to, 0);
        rst_n = 1'b1;

        // R2: quiet bus, tick every cycle -> exactly one pulse; R3: no second.
        phase = "R2"; clear_counts();
        run(IDLE + 2);
        chk("R2", "idle pulses after limit", c_idle, 1);
        phase = "R3"; clear_counts();
        run(3 * IDLE);
        chk("R3", "no repeat without activity", c_idle, 0);
        rx_line = 1'b0; run(3); rx_line = 1'b1;
        clear_counts();
        run(gap_after(IDLE));
        chk("R3", "rearmed after activity", c_idle, 1);

        // R1: falling edges every IDLE/2 cycles hold the idle timer off.
        phase = "R1";
        rx_line = 1'b0; run(2); rx_line = 1'b1; clear_counts();
        for (int k = 0; k < 8; k++) begin
            run(IDLE / 4); rx_line = 1'b0; run(IDLE / 4); rx_line = 1'b1;
        end
        chk("R1", "no idle pulse with activity", c_idle, 0);

        // R4: single wakeup window.
        phase = "R4"; clear_counts();
        pulse_wake();
        run(W1 + 4);
        chk("R4", "once pulses", c_once, 1);
        run(2 * W1);
        chk("R4", "no pulse without new wakeup", c_once, 1);
        sync_brk = 1'b1; step(); sync_brk = 1'b0;

        // R5: three unanswered wakeups.
        phase = "R5"; clear_counts();
        pulse_wake(); run(W1 + 4);
        pulse_wake(); run(W1 + 4);
        pulse_wake(); run(W3 + 4);
        chk("R5", "once pulses in round", c_once, 2);
        chk("R5", "round pulses", c_round, 1);
        clear_counts();
        pulse_wake(); run(W1 + 4);
        chk("R5", "count restarted after round", c_once, 1);
        chk("R5", "no extra round pulse", c_round, 0);
        sync_brk = 1'b1; step(); sync_brk = 1'b0;

        // R6: sync break stops a window and clears the attempt count.
        phase = "R6"; clear_counts();
        pulse_wake(); run(W1 / 2);
        sync_brk = 1'b1; step(); sync_brk = 1'b0;
        run(2 * W1);
        chk("R6", "stopped window", c_once, 0);
        pulse_wake(); run(W1 + 4);
        pulse_wake(); run(W1 + 4);
        sync_brk = 1'b1; wake_sent = 1'b1; step(); sync_brk = 1'b0; wake_sent = 1'b0;
        run(W1 + 4);
        chk("R6", "break beats wakeup", c_once, 2);
        clear_counts();
        pulse_wake(); run(W3 + 4);
        chk("R6", "count cleared, short window", c_once, 1);
        chk("R6", "count cleared, no round", c_round, 0);
        sync_brk = 1'b1; step(); sync_brk = 1'b0;

        // R7: wakeup strobes inside an open window are ignored.
        phase = "R7"; clear_counts();
        pulse_wake(); run(W1 / 2);
        pulse_wake(); run(W1 / 2 + 3);
        chk("R7", "window not restarted", c_once, 1);
        pulse_wake(); run(W1 + 4);
        pulse_wake(); run(W3 / 2);
        pulse_wake(); run(W3 / 2 + 4);
        chk("R7", "round after ignored strobe", c_round, 1);
        chk("R7", "two once pulses", c_once, 2);

        // R8: LIN mode off.
        phase = "R8"; clear_counts();
        lin_mode = 1'b0;
        pulse_wake(); run(2 * IDLE);
        chk("R8", "no idle pulse when off", c_idle, 0);
        chk("R8", "no wake pulse when off", c_once + c_round, 0);
        lin_mode = 1'b1;

        // R9: soft reset drops a running window.
        phase = "R9"; clear_counts();
        pulse_wake(); run(W1 / 2);
        soft_rst = 1'b1; step(); soft_rst = 1'b0;
        run(2 * W1);
        chk("R9", "window dropped", c_once, 0);

        // R11: random mix against the reference model.
        phase = "R11"; tick_rand = 1;
        for (int i = 0; i < 4000; i++) begin
            wake_sent = ($urandom % 16 == 0);
            sync_brk  = ($urandom % 120 == 0);
            soft_rst  = ($urandom % 400 == 0);
            if ($urandom % 300 == 0) lin_mode = ~lin_mode;
            if ($urandom % 40 == 0)  rx_line = ~rx_line;
            step();
        end
        done = 1;
        summary();
    end

endmodule